// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the device side of a three-wire serial EEPROM: chip select, serial clock and serial data in, with one serial data out. It samples all three inputs in the system clock domain. It finds a start bit and then reads a two-bit opcode and a word address. From these it runs read, word write, word erase, whole-array erase, whole-array write, write enable and write disable. The commands act on an internal register-array memory.

Programming commands do not act while the frame is being clocked in. They arm the block, and the falling edge of chip select, which must come before the next serial clock rise, launches a self-timed program cycle. A counter on the system clock sets the length of that cycle, and no serial clock edges are needed while it runs. A host that selects the device again sees data-out held low while the cycle runs and high once it has finished. The drive enable of data-out is low whenever chip select is low. All programming sits behind a write-enable latch, which is clear after reset.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the write-enable latch is clear, every word reads as all ones, and `doOe` is low.
- R2: A frame of start 1, opcode 00 and address top bits 11 sets the write-enable latch. Top bits 00 clear it. While the latch is clear, write, erase, erase-all and write-all leave memory unchanged and start no cycle. A disable issued later blocks such commands again.
- R3: Read (start 1, opcode 10, address MSB first) works whatever the latch holds. After the rising serial clock edge that samples the last address bit, `doOut` shows a dummy 0. Each following rising edge moves out the next data bit, MSB first.
- R4: Erase (start 1, opcode 11, address) sets the addressed word to all ones and leaves the other words unchanged.
- R5: Erase-all (opcode 00, address top bits 10) sets every word to all ones.
- R6: Write (opcode 01, address, DATA_W data bits MSB first) stores the data word. Write-all (opcode 00, top bits 01, data) stores the data word in every location with no prior erase.
- R7: A programming command is launched only when chip select falls after its last bit and before the next rising serial clock edge. If another rising edge comes first, the command is discarded and memory is unchanged.
- R8: While chip select is high during a program cycle, `doOe` is high and `doOut` is 0. After the cycle, with chip select high, `doOut` is 1 until the next start bit. With chip select low, `doOe` is low.
- R9: The program cycle lasts PROG_CYCLES system clocks with no serial clock activity, and memory changes only at its end. Frames sent during the cycle, enable and disable included, have no effect.
- R10: Zero bits clocked before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select, active high, asynchronous to clk |
| skIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data in, sampled on rising serial clock |
| doOut | output | 1 | Serial data out value (read bits or busy/ready) |
| doOe | output | 1 | Drive enable for data out; pad is high impedance when low |

## Verification
The arming state is where two events compete: chip select falling and the next rising serial clock edge. The bench provokes both outcomes. In the first, it drops chip select right after the last data bit. In the second, it adds one extra serial clock pulse before dropping chip select. It judges each outcome by polling status and reading the word back. A second contest is between a running program cycle and a new frame. A disable frame is sent while the cycle is busy, and a write that follows must still succeed.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_ERASE,
    OP_WRAL,
    OP_ERAL
  } opKind_e;

  typedef struct packed {
    logic    shHdr;
    logic    shData;
    logic    ldRead;
    logic    shRead;
    logic    commit;
    opKind_e kind;
  } strobe_t;
endpackage

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       skIn,
  input  logic       diIn,
  input  logic [1:0] hdrOp,
  input  logic [1:0] hdrSub,
  output strobe_t    st,
  output logic       diBit,
  output logic       csSel,
  output logic       inBusy,
  output logic       inRead,
  output logic       rdyFlag
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int MAXW  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int BIT_W = $clog2(MAXW);
  localparam int CNT_W = $clog2(PROG_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DECODE, ST_DATA, ST_ARM, ST_READ, ST_SKIP, ST_BUSY
  } state_e;

  logic [SYNC_STAGES-1:0] csPipe, skPipe, diPipe;
  logic csS, skS, diS, skD, skRise;
  state_e state;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] cnt;
  logic wenLatch;
  opKind_e pendOp, decOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe <= '0;
      skPipe <= '0;
      diPipe <= '0;
      skD    <= 1'b0;
    end else begin
      csPipe <= {csPipe[SYNC_STAGES-2:0], csIn};
      skPipe <= {skPipe[SYNC_STAGES-2:0], skIn};
      diPipe <= {diPipe[SYNC_STAGES-2:0], diIn};
      skD    <= skS;
    end
  end

  assign csS    = csPipe[SYNC_STAGES-1];
  assign skS    = skPipe[SYNC_STAGES-1];
  assign diS    = diPipe[SYNC_STAGES-1];
  assign skRise = skS & ~skD;
  assign diBit  = diS;
  assign csSel  = csS;
  assign inBusy = (state == ST_BUSY);
  assign inRead = (state == ST_READ);

  always_comb begin
    unique case (hdrOp)
      2'b01:   decOp = OP_WRITE;
      2'b11:   decOp = OP_ERASE;
      2'b00:   decOp = (hdrSub == 2'b01) ? OP_WRAL :
                       (hdrSub == 2'b10) ? OP_ERAL : OP_NONE;
      default: decOp = OP_NONE;
    endcase
  end

  always_comb begin
    st      = '0;
    st.kind = pendOp;
    unique case (state)
      ST_HDR:    st.shHdr  = csS & skRise;
      ST_DATA:   st.shData = csS & skRise;
      ST_DECODE: st.ldRead = (hdrOp == 2'b10);
      ST_READ:   st.shRead = csS & skRise;
      ST_BUSY:   st.commit = (cnt == LAST);
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      cnt      <= '0;
      wenLatch <= 1'b0;
      rdyFlag  <= 1'b0;
      pendOp   <= OP_NONE;
    end else begin
      unique case (state)
        ST_IDLE:
          if (csS && skRise && diS) begin
            state   <= ST_HDR;
            bitCnt  <= '0;
            rdyFlag <= 1'b0;
          end
        ST_HDR:
          if (!csS) state <= ST_IDLE;
          else if (skRise) begin
            if (bitCnt == BIT_W'(HDR_W - 1)) state <= ST_DECODE;
            else bitCnt <= bitCnt + 1'b1;
          end
        ST_DECODE: begin
          pendOp <= decOp;
          if (hdrOp == 2'b10) state <= ST_READ;
          else if (decOp == OP_WRITE || decOp == OP_WRAL) begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end else if (decOp != OP_NONE) state <= ST_ARM;
          else begin
            if (hdrSub == 2'b11) wenLatch <= 1'b1;
            if (hdrSub == 2'b00) wenLatch <= 1'b0;
            state <= ST_SKIP;
          end
        end
        ST_DATA:
          if (!csS) state <= ST_IDLE;
          else if (skRise) begin
            if (bitCnt == BIT_W'(DATA_W - 1)) state <= ST_ARM;
            else bitCnt <= bitCnt + 1'b1;
          end
        ST_ARM:
          if (!csS) begin
            state <= wenLatch ? ST_BUSY : ST_IDLE;
            cnt   <= '0;
          end else if (skRise) state <= ST_SKIP;
        ST_READ: if (!csS) state <= ST_IDLE;
        ST_SKIP: if (!csS) state <= ST_IDLE;
        ST_BUSY:
          if (cnt == LAST) begin
            state   <= ST_IDLE;
            rdyFlag <= 1'b1;
          end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_COMMIT_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> wenLatch); // R2
  AST_WEN_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wenLatch) |-> $past(state) == ST_DECODE); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && cnt != LAST) |=> state == ST_BUSY); // R9
  AST_LATE_CS_DISCARDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARM && csS && skRise) |=> state != ST_BUSY); // R7
endmodule

// File: rtl/mw_data.sv
module mw_data
  import mw_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    st,
  input  logic       diBit,
  output logic [1:0] hdrOp,
  output logic [1:0] hdrSub,
  output logic       rdBit
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [HDR_W-1:0]  hdrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W:0]   rdReg;
  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] addrW;

  assign addrW  = hdrReg[ADDR_W-1:0];
  assign hdrOp  = hdrReg[HDR_W-1:HDR_W-2];
  assign hdrSub = hdrReg[ADDR_W-1:ADDR_W-2];
  assign rdBit  = rdReg[DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg  <= '0;
      dataReg <= '0;
      rdReg   <= '0;
      for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
    end else begin
      if (st.shHdr)  hdrReg  <= {hdrReg[HDR_W-2:0], diBit};
      if (st.shData) dataReg <= {dataReg[DATA_W-2:0], diBit};
      if (st.ldRead) rdReg <= {1'b0, memArr[addrW]};
      else if (st.shRead) rdReg <= {rdReg[DATA_W-1:0], 1'b0};
      if (st.commit) begin
        unique case (st.kind)
          OP_WRITE: memArr[addrW] <= dataReg;
          OP_ERASE: memArr[addrW] <= '1;
          OP_WRAL:  for (int i = 0; i < DEPTH; i++) memArr[i] <= dataReg;
          OP_ERAL:  for (int i = 0; i < DEPTH; i++) memArr[i] <= '1;
          default:  ;
        endcase
      end
    end
  end

  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && st.kind == OP_ERASE) |=> memArr[addrW] == {DATA_W{1'b1}}); // R4
  AST_WRAL_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (st.commit && st.kind == OP_WRAL) |=> memArr[DEPTH-1] == $past(dataReg)); // R6
  AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(memArr[0])); // R9
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut,
  output logic doOe
);
  strobe_t    st;
  logic       diBit, csSel, inBusy, inRead, rdyFlag, rdBit;
  logic [1:0] hdrOp, hdrSub;

  mw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .hdrOp(hdrOp), .hdrSub(hdrSub), .st(st), .diBit(diBit), .csSel(csSel),
    .inBusy(inBusy), .inRead(inRead), .rdyFlag(rdyFlag)
  );

  mw_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .st(st), .diBit(diBit),
    .hdrOp(hdrOp), .hdrSub(hdrSub), .rdBit(rdBit)
  );

  assign doOe  = csSel & (inBusy | inRead | rdyFlag);
  assign doOut = inRead ? rdBit : ~inBusy;

  // synchroniser depth is SYNC_STAGES (2)
  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    doOe |-> $past(csIn, 2)); // R8
endmodule

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 16;
  localparam int PROG   = 300;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic doOut, doOe;
  int total = 0, bad = 0;

  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] gotQ[$];
  string tagQ[$];
  event gotEv;

  always #2 clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG)) i_mw_eeprom_slave (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di), .doOut(doOut), .doOe(doOe)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sk = 1'b0; di = b; tick(8);
    sk = 1'b1; tick(8);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic beginFrame();
    cs = 1'b1; sk = 1'b0; tick(4);
  endtask

  task automatic endFrame();
    sk = 1'b0; cs = 1'b0; tick(6);
  endtask

  task automatic header(input logic [1:0] op, input logic [ADDR_W-1:0] addr);
    sendBit(1'b1); sendBits(32'(op), 2); sendBits(32'(addr), ADDR_W);
  endtask

  task automatic pollCycle(input string tag, input bit expectBusy);
    cs = 1'b1; tick(6);
    if (expectBusy) begin
      check(doOe === 1'b1 && doOut === 1'b0, tag, "R8 busy low", {doOe, doOut}, 2'b10);
      tick(PROG - 40);
      check(doOe === 1'b1 && doOut === 1'b0, "R9", "still busy", {doOe, doOut}, 2'b10);
      tick(60);
      check(doOe === 1'b1 && doOut === 1'b1, "R8", "ready high", {doOe, doOut}, 2'b11);
    end else begin
      check(doOe === 1'b0, tag, "no cycle started", doOe, 1'b0);
    end
    cs = 1'b0; tick(4);
    check(doOe === 1'b0, "R8", "released when deselected", doOe, 1'b0);
  endtask

  task automatic cmdShort(input logic [1:0] op, input logic [ADDR_W-1:0] addr);
    beginFrame(); header(op, addr); endFrame();
  endtask

  task automatic cmdData(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                         input logic [DATA_W-1:0] d);
    beginFrame(); header(op, addr); sendBits(32'(d), DATA_W); endFrame();
  endtask

  task automatic readWord(input logic [ADDR_W-1:0] addr, input string tag, input int lead);
    logic [DATA_W-1:0] w;
    w = '0;
    expQ.push_back(model[addr]);
    tagQ.push_back(tag);
    beginFrame();
    repeat (lead) sendBit(1'b0);
    header(2'b10, addr);
    check(doOe === 1'b1 && doOut === 1'b0, "R3", "dummy zero", {doOe, doOut}, 2'b10);
    for (int i = 0; i < DATA_W; i++) begin
      sendBit(1'b0);
      w = {w[DATA_W-2:0], doOut};
    end
    endFrame();
    gotQ.push_back(w);
    -> gotEv;
  endtask

  initial begin
    forever begin
      @(gotEv);
      while (gotQ.size() > 0 && expQ.size() > 0) begin
        logic [DATA_W-1:0] g, e;
        string t;
        g = gotQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
        check(g === e, t, "read data", 32'(g), 32'(e));
      end
    end
  end

  task automatic finishRun();
    tick(4);
    check(expQ.size() == 0, "R3", "scoreboard drained", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    tick(5); rstN = 1'b1; tick(5);
    check(doOe === 1'b0, "R1", "oe after reset", doOe, 1'b0);
    readWord(9'd0, "R1", 0);

    // R2: write while disabled is ignored
    cmdData(2'b01, 9'd5, 16'h1234);
    pollCycle("R2", 1'b0);
    readWord(9'd5, "R2", 0);

    // R2 enable, R6 write with status polling
    cmdShort(2'b00, 9'b110000000);
    cmdData(2'b01, 9'd5, 16'hA5C3); model[5] = 16'hA5C3;
    pollCycle("R8", 1'b1);
    readWord(9'd5, "R6", 0);
    readWord(9'd5, "R10", 3);

    cmdData(2'b01, 9'd7, 16'h0F0F); model[7] = 16'h0F0F;
    tick(PROG + 20);
    readWord(9'd7, "R6", 0);

    // R4 erase single word
    cmdShort(2'b11, 9'd5); model[5] = '1;
    tick(PROG + 20);
    readWord(9'd5, "R4", 0);
    readWord(9'd7, "R4", 0);

    // R7 late chip select: extra clock before deselect
    beginFrame(); header(2'b01, 9'd9); sendBits(32'h0000_BEEF, DATA_W); sendBit(1'b0);
    endFrame();
    pollCycle("R7", 1'b0);
    readWord(9'd9, "R7", 0);

    // R9 disable frame during busy is ignored
    cmdData(2'b01, 9'd11, 16'h1111); model[11] = 16'h1111;
    beginFrame(); header(2'b00, 9'b000000000); endFrame();
    tick(PROG);
    cmdData(2'b01, 9'd12, 16'h2222); model[12] = 16'h2222;
    tick(PROG + 20);
    readWord(9'd11, "R9", 0);
    readWord(9'd12, "R9", 0);

    // R2 disable blocks erase and erase-all
    cmdShort(2'b00, 9'b000000000);
    cmdShort(2'b11, 9'd12);
    pollCycle("R2", 1'b0);
    cmdShort(2'b00, 9'b100000000);
    tick(PROG + 20);
    readWord(9'd12, "R2", 0);
    readWord(9'd7, "R2", 0);

    // R6 write-all
    cmdShort(2'b00, 9'b110000000);
    cmdData(2'b00, 9'b010000000, 16'h3C3C);
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h3C3C;
    tick(PROG + 20);
    readWord(9'd0, "R6", 0);
    readWord(9'd511, "R6", 0);
    readWord(9'd12, "R6", 0);

    // R5 erase-all
    cmdShort(2'b00, 9'b100000000);
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    pollCycle("R5", 1'b1);
    readWord(9'd0, "R5", 0);
    readWord(9'd300, "R5", 0);

    finishRun();
  end
endmodule